// File: doc/BRIEF.md
# Write-Buffer Status Flag Timer

This block produces the status word that a host reads to learn whether a peripheral write buffer is still busy. Each pulse on the write strobe marks one buffered write. The pulse starts or extends a set of deadlines that are measured against a free-running tick counter.

Three flags come from those deadlines:
- A short "recent write" flag.
- A mid-range flag that comes on after a delay and goes off once its window ends.
- A long-range flag whose window is pushed out further by every write that lands while the flag is still pending.

Three fixed bits always read as one. Everything else in the word reads as zero.

The status word is combinational. It is computed from the current counter value and the stored deadlines, so the host can sample it in any cycle. The write strobe is a plain control pin and is never back-pressured: every strobe seen outside reset is taken. The tick counter advances by one every clock and wraps at its width. After a wrap, any deadline that lies beyond the last write's timestamp is cleared, so a stale value cannot mask or hold a flag.

Top module: `wrbuf_status_timer`

## Requirements
- R1: A synchronous reset clears the tick counter, every deadline and the last-write timestamp to zero. In the first cycle after reset the status word reads 32'h0000000E.
- R2: A write taken at tick t sets the pulse deadline to t+8 (modulo the counter width). Bit 5 reads 1 exactly while the current tick is below the pulse deadline.
- R3: On a write at tick t, the mid-flag on-time is moved to t+8 only when the stored mid off-time is strictly below t. Otherwise the on-time is kept.
- R4: On every write at tick t, the mid-flag off-time becomes max(t, old off-time)+16.
- R5: Bit 4 reads 0 when the current tick has reached the mid off-time, or when the current tick plus 8 is below the mid off-time. Otherwise bit 4 reads 1 once the tick has reached the mid on-time, and 0 before that.
- R6: On a write at tick t, if the long off-time is strictly below t, the long on-time becomes t+24 and the long off-time becomes that on-time plus 24. Otherwise only the off-time is increased by 24. Both 24-tick additions saturate at the counter's all-ones value instead of wrapping.
- R7: Bit 0 reads 1 exactly while the current tick is at or above the long on-time and below the long off-time.
- R8: Bits 3, 2 and 1 always read 1. Bits 31 to 6 always read 0.
- R9: When the current tick is below the last-write timestamp, any deadline greater than that timestamp is treated as zero, and it is stored as zero from then on.
- R10: A write strobe that is asserted while reset is held has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the tick counter advances on each rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | One buffered write per cycle in which it is high |
| status_word | output | 32 | Status flags, computed combinationally from the current tick |

## Verification
The bench builds the block with a 10-bit tick counter. The counter therefore wraps every 1024 cycles, and the run passes through the wrap several times. This makes the deadline fix-up after a wrap, and saturation of the long timer at the all-ones value, reachable in a short run. Writes are forced just before the wrap so that both effects are exercised. The delays keep their default values of 8, 16 and 24 ticks. The run covers isolated writes, back-to-back bursts that stack the mid and long windows, sparse and dense random traffic, and a reset applied while the strobe is held high.

// File: rtl/wrbuf_stat_pkg.sv
package wrbuf_stat_pkg;
  // Deadline slots held by the timer bank
  localparam int SLOT_PULSE_OFF = 0;
  localparam int SLOT_MID_ON    = 1;
  localparam int SLOT_MID_OFF   = 2;
  localparam int SLOT_LONG_ON   = 3;
  localparam int SLOT_LONG_OFF  = 4;
  localparam int NUM_SLOTS      = 5;

  // Status word layout
  localparam int STAT_W     = 32;
  localparam int BIT_PULSE  = 5;
  localparam int BIT_MID    = 4;
  localparam int BIT_LONG   = 0;
  localparam logic [STAT_W-1:0] FIXED_ONES = 32'h0000_000E;
endpackage

// File: rtl/wrbuf_tick_counter.sv
module wrbuf_tick_counter #(
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [TICK_W-1:0] tick
);
  always_ff @(posedge clk) begin
    if (rst) tick <= '0;
    else     tick <= tick + 1'b1;
  end
endmodule

// File: rtl/wrbuf_deadline_bank.sv
module wrbuf_deadline_bank
  import wrbuf_stat_pkg::*;
#(
  parameter int TICK_W    = 32,
  parameter int PULSE_DLY = 8,
  parameter int MID_DLY   = 16,
  parameter int LONG_DLY  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [TICK_W-1:0] now,
  output logic [TICK_W-1:0] dl_eff [NUM_SLOTS]
);
  localparam logic [TICK_W-1:0] PULSE_INC = TICK_W'(PULSE_DLY);
  localparam logic [TICK_W-1:0] MID_INC   = TICK_W'(MID_DLY);
  localparam logic [TICK_W:0]   LONG_INC  = (TICK_W+1)'(LONG_DLY);

  logic [TICK_W-1:0] dl_q   [NUM_SLOTS];
  logic [TICK_W-1:0] dl_nxt [NUM_SLOTS];
  logic [TICK_W-1:0] last_q;
  logic              wrapped;
  logic [TICK_W-1:0] mid_base;
  logic [TICK_W-1:0] long_on_new;

  function automatic logic [TICK_W-1:0] sat_long(input logic [TICK_W-1:0] a);
    logic [TICK_W:0] s;
    s = {1'b0, a} + LONG_INC;
    return s[TICK_W] ? {TICK_W{1'b1}} : s[TICK_W-1:0];
  endfunction

  assign wrapped = now < last_q;

  // After a counter wrap, deadlines beyond the last write are stale
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_fix
    assign dl_eff[g] = (wrapped && dl_q[g] > last_q) ? '0 : dl_q[g];
  end

  assign mid_base    = (now > dl_eff[SLOT_MID_OFF]) ? now : dl_eff[SLOT_MID_OFF];
  assign long_on_new = sat_long(now);

  always_comb begin
    dl_nxt = dl_eff;
    if (wr_stb) begin
      dl_nxt[SLOT_PULSE_OFF] = now + PULSE_INC;
      if (dl_eff[SLOT_MID_OFF] < now) dl_nxt[SLOT_MID_ON] = now + PULSE_INC;
      dl_nxt[SLOT_MID_OFF] = mid_base + MID_INC;
      if (dl_eff[SLOT_LONG_OFF] < now) begin
        dl_nxt[SLOT_LONG_ON]  = long_on_new;
        dl_nxt[SLOT_LONG_OFF] = sat_long(long_on_new);
      end else begin
        dl_nxt[SLOT_LONG_OFF] = sat_long(dl_eff[SLOT_LONG_OFF]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) dl_q[i] <= '0;
    end else begin
      if (wr_stb) last_q <= now;
      for (int i = 0; i < NUM_SLOTS; i++) dl_q[i] <= dl_nxt[i];
    end
  end
endmodule

// File: rtl/wrbuf_flag_decode.sv
module wrbuf_flag_decode
  import wrbuf_stat_pkg::*;
#(
  parameter int TICK_W    = 32,
  parameter int PULSE_DLY = 8
) (
  input  logic [TICK_W-1:0] now,
  input  logic [TICK_W-1:0] dl [NUM_SLOTS],
  output logic [STAT_W-1:0] status
);
  logic [TICK_W-1:0] horizon;
  logic              mid_done, mid_far, mid_started;

  assign horizon     = now + TICK_W'(PULSE_DLY);
  assign mid_done    = dl[SLOT_MID_OFF] <= now;
  assign mid_far     = horizon < dl[SLOT_MID_OFF];
  assign mid_started = dl[SLOT_MID_ON] <= now;

  always_comb begin
    status            = FIXED_ONES;
    status[BIT_PULSE] = now < dl[SLOT_PULSE_OFF];
    status[BIT_MID]   = !mid_done && !mid_far && mid_started;
    status[BIT_LONG]  = (now < dl[SLOT_LONG_OFF]) && (dl[SLOT_LONG_ON] <= now);
  end
endmodule

// File: rtl/wrbuf_status_timer.sv
module wrbuf_status_timer
  import wrbuf_stat_pkg::*;
#(
  parameter int TICK_W    = 32,
  parameter int PULSE_DLY = 8,
  parameter int MID_DLY   = 16,
  parameter int LONG_DLY  = 24
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_stb,
  output logic [31:0] status_word
);
  logic [TICK_W-1:0] now;
  logic [TICK_W-1:0] dl [NUM_SLOTS];

  wrbuf_tick_counter #(.TICK_W(TICK_W)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(now)
  );

  wrbuf_deadline_bank #(
    .TICK_W(TICK_W), .PULSE_DLY(PULSE_DLY), .MID_DLY(MID_DLY), .LONG_DLY(LONG_DLY)
  ) u_bank (
    .clk   (clk),
    .rst   (rst),
    .wr_stb(wr_stb),
    .now   (now),
    .dl_eff(dl)
  );

  wrbuf_flag_decode #(.TICK_W(TICK_W), .PULSE_DLY(PULSE_DLY)) u_dec (
    .now   (now),
    .dl    (dl),
    .status(status_word)
  );
endmodule

// File: rtl/wrbuf_status_timer_chk.sv
module wrbuf_status_timer_chk #(
  parameter int TICK_W    = 32,
  parameter int PULSE_DLY = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_stb,
  input logic [TICK_W-1:0] now,
  input logic [31:0]       status_word
);
  localparam logic [TICK_W-1:0] NO_WRAP_LIMIT = {TICK_W{1'b1}} - TICK_W'(PULSE_DLY);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: first cycle out of reset shows only the fixed bits
  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (status_word == 32'h0000000E));

  // R2: a write away from the wrap point raises the pulse flag next cycle
  p_pulse_after_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && now < NO_WRAP_LIMIT) |=> status_word[5]);

  // R5: mid flag only shows once the latest write's pulse has ended
  p_mid_excl_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    status_word[4] |-> !status_word[5]);

  // R8: fixed and unused bits
  p_fixed_bits_r8: assert property (@(posedge clk) disable iff (rst)
    (status_word[3:1] == 3'b111) && (status_word[31:6] == 26'd0));
endmodule

bind wrbuf_status_timer wrbuf_status_timer_chk #(
  .TICK_W(TICK_W), .PULSE_DLY(PULSE_DLY)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_stb     (wr_stb),
  .now        (now),
  .status_word(status_word)
);

// File: tb/test_wrbuf_status_timer.sv
module test_wrbuf_status_timer;
  localparam int PERIOD = 10;
  localparam int TW     = 10;
  localparam longint unsigned MASK = (64'd1 << TW) - 1;
  localparam int RUN_CYC = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0;
  logic [31:0] status_word;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Reference state
  longint unsigned m_now, m_last, m_p5, m_m4on, m_m4off, m_l0on, m_l0off;

  wrbuf_status_timer #(.TICK_W(TW)) i_wrbuf_status_timer (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .status_word(status_word)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic model_reset();
    m_now = 0; m_last = 0; m_p5 = 0; m_m4on = 0; m_m4off = 0; m_l0on = 0; m_l0off = 0;
  endtask

  function automatic longint unsigned fixv(longint unsigned v);
    // R9: stale deadlines after a wrap read as zero
    if (m_now < m_last && v > m_last) return 0;
    return v;
  endfunction

  function automatic longint unsigned sat24(longint unsigned v);
    return (v + 24 > MASK) ? MASK : v + 24;
  endfunction

  function automatic logic [31:0] model_status();
    logic [31:0] s;
    longint unsigned p5, on4, off4, on0, off0;
    p5 = fixv(m_p5); on4 = fixv(m_m4on); off4 = fixv(m_m4off);
    on0 = fixv(m_l0on); off0 = fixv(m_l0off);
    s = 32'h0000000E;
    s[5] = m_now < p5;
    s[4] = !(off4 <= m_now) && !(((m_now + 8) & MASK) < off4) && (on4 <= m_now);
    s[0] = (m_now < off0) && (on0 <= m_now);
    return s;
  endfunction

  task automatic model_step(input bit w);
    m_p5 = fixv(m_p5); m_m4on = fixv(m_m4on); m_m4off = fixv(m_m4off);
    m_l0on = fixv(m_l0on); m_l0off = fixv(m_l0off);
    if (w) begin
      m_last = m_now;
      m_p5 = (m_now + 8) & MASK;
      if (m_m4off < m_now) m_m4on = (m_now + 8) & MASK;
      m_m4off = (((m_now > m_m4off) ? m_now : m_m4off) + 16) & MASK;
      if (m_l0off < m_now) begin
        m_l0on = sat24(m_now);
        m_l0off = sat24(m_l0on);
      end else begin
        m_l0off = sat24(m_l0off);
      end
    end
    m_now = (m_now + 1) & MASK;
  endtask

  task automatic chk_bit(input string req, input logic a, input logic e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s at tick %0d: actual %b expected %b", req, m_now, a, e);
    end
  endtask

  task automatic chk_word(input string req, input logic [31:0] a, input logic [31:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s at tick %0d: actual %h expected %h", req, m_now, a, e);
    end
  endtask

  task automatic compare_all();
    logic [31:0] e;
    e = model_status();
    chk_bit("R2 pulse bit5", status_word[5], e[5]);
    chk_bit("R3/R4/R5 mid bit4", status_word[4], e[4]);
    chk_bit("R6/R7 long bit0", status_word[0], e[0]);
    chk_word("R8 fixed bits", status_word & 32'hFFFF_FFCE, 32'h0000_000E);
  endtask

  function automatic bit pick_wr(int cyc);
    if (m_now >= 995 && m_now < 1000) return 1'b1;   // near-wrap saturation, R6 and R9
    if (cyc < 600)  return (cyc % 60) == 5;          // isolated writes
    if (cyc < 1400) return (cyc % 50) < 3;           // bursts stack the windows
    if (cyc < 2600) return ($urandom % 4) == 0;      // dense random traffic
    if (cyc < 3800) return ($urandom % 12) == 0;     // sparse random traffic
    return (cyc % 37) == 0 || (cyc % 41) == 0;
  endfunction

  initial begin
    bit w;
    model_reset();
    rst = 1'b1;
    wr_stb = 1'b1;   // R10: strobe held during reset is ignored
    repeat (3) @(negedge clk);
    chk_word("R1 reset status", status_word, 32'h0000000E);
    chk_word("R10 strobe in reset", status_word, 32'h0000000E);
    wr_stb = 1'b0;
    rst = 1'b0;
    for (int cyc = 0; cyc < RUN_CYC; cyc++) begin
      if (cyc == 3000) begin
        // Reset during activity, with the strobe held high (R1, R10)
        rst = 1'b1;
        wr_stb = 1'b1;
        repeat (3) @(negedge clk);
        model_reset();
        chk_word("R1 mid-run reset status", status_word, 32'h0000000E);
        wr_stb = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        model_step(1'b0);
        chk_word("R10 no write taken in reset", status_word, 32'h0000000E);
      end
      compare_all();
      w = pick_wr(cyc);
      wr_stb = w;
      model_step(w);
      @(negedge clk);
    end
    wr_stb = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule